// File: doc/BRIEF.md
# Bitsliced 384-bit Round Permutation Engine

This block computes a keyless permutation over a 384-bit state. The state is organised as four 96-bit rows. Each round does three things in order. It adds a 7-bit round constant into the low end of row 0. It applies a 4-input nonlinear substitution to every one of the 96 columns at once. It then rotates rows 1, 2 and 3 left by fixed distances. A 7-bit linear feedback shift register supplies the round constants. The whole round is combinational, and its result is registered once per clock, so N rounds take N cycles.

A host puts a state and a round count on the inputs and pulses `start`. The engine raises `busy` while it iterates. It pulses `done` for one cycle when the last round lands, and it then holds the result until the host starts the next job. A round count of zero passes the loaded state straight through. The host may start a new job in the same cycle that `done` is high.

Top module: `sperm_core`

## Requirements
- R1: State bits [96r+95:96r] of `state_in` and `state_out` form row r (r = 0..3). Column j is made of bit j of each of the four rows.
- R2: Each round XORs the current 7-bit constant into bits [6:0] of row 0, before the substitution.
- R3: The substitution works on row slices a0..a3 and a temporary t. The steps are: t=a1; a0=~a0; a1&=a0; a1^=a2; a2|=t; a0^=a3; a2^=a0; t^=a3; a0&=a1; a3^=a1; a0^=t; t&=a2; a1^=t. The results replace rows 0..3.
- R4: After the substitution, each row is rotated toward higher bit indices. Row 0 does not move, row 1 moves by 1, row 2 by 8 and row 3 by 55.
- R5: The constant is 0x01 for the first round of every job. It advances once per round as {c[5:0], c[6]^c[5]}, which gives 0x01, 0x02, 0x04, 0x08, 0x10, 0x20, 0x41, 0x03 and so on, with period 127.
- R6: A `start` accepted while idle loads `state_in` and `rounds_in`. Exactly `rounds_in` rounds then run, one per clock. `done` rises `rounds_in` cycles after the first cycle that `busy` is high.
- R7: `busy` is high only while rounds remain. `done` is a single-cycle pulse. When it is high, `state_out` holds the state after the final round.
- R8: While idle and with no accepted start, `state_out` does not change.
- R9: A `start` seen while `busy` is high has no effect, and this includes the cycle that performs the final round.
- R10: `rounds_in` = 0 raises `done` in the cycle after the start with `state_out` equal to `state_in`, and `busy` never rises.
- R11: A `start` in the cycle where `done` is high is accepted, because `busy` is already low then.
- R12: After reset, `busy` = 0, `done` = 0 and `state_out` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a job when idle |
| rounds_in | input | 8 | Number of rounds to run |
| state_in | input | 384 | State to permute, rows packed as in R1 |
| busy | output | 1 | Rounds are in progress |
| done | output | 1 | One-cycle pulse when the job finishes |
| state_out | output | 384 | Current or final state |

## Verification
Two events can fall on the same clock edge. One is a request arriving as a job finishes; the other is a request arriving while rounds are still running. The bench raises `start` with a different state during the final round, where it must be dropped and the first result must survive. It also raises `start` in the cycle `done` is high, where the second job must be taken and produce its own reference result. Each case is judged against a round model computed in the bench, and the model's constant sequence is checked against the listed values and its period of 127.

// File: rtl/sperm_pkg.sv
package sperm_pkg;
    localparam int unsigned ROW_W_DEF = 96;
    localparam int unsigned ROWS      = 4;
    localparam int unsigned RC_W_DEF  = 7;
    localparam int unsigned CNT_W_DEF = 8;
    localparam int unsigned ROT1_DEF  = 1;
    localparam int unsigned ROT2_DEF  = 8;
    localparam int unsigned ROT3_DEF  = 55;
endpackage

// File: rtl/sperm_rotl.sv
module sperm_rotl #(
    parameter int unsigned W = 96,
    parameter int unsigned K = 1
) (
    input  logic [W-1:0] x,
    output logic [W-1:0] y
);
    localparam int unsigned KM = K % W;

    generate
        if (KM == 0) begin : g_pass
            assign y = x;
        end else begin : g_rot
            assign y = {x[W-1-KM:0], x[W-1:W-KM]};
        end
    endgenerate
endmodule

// File: rtl/sperm_sbox.sv
module sperm_sbox #(
    parameter int unsigned W = 96
) (
    input  logic [W-1:0] i0,
    input  logic [W-1:0] i1,
    input  logic [W-1:0] i2,
    input  logic [W-1:0] i3,
    output logic [W-1:0] o0,
    output logic [W-1:0] o1,
    output logic [W-1:0] o2,
    output logic [W-1:0] o3
);
    // every column handled by an identical 4-bit cell
    for (genvar j = 0; j < W; j++) begin : g_col
        logic a0, a1, a2, a3, t;
        always_comb begin
            t  = i1[j];
            a0 = ~i0[j];
            a1 = i1[j] & a0;
            a1 = a1 ^ i2[j];
            a2 = i2[j] | t;
            a0 = a0 ^ i3[j];
            a2 = a2 ^ a0;
            t  = t ^ i3[j];
            a0 = a0 & a1;
            a3 = i3[j] ^ a1;
            a0 = a0 ^ t;
            t  = t & a2;
            a1 = a1 ^ t;
        end
        assign o0[j] = a0;
        assign o1[j] = a1;
        assign o2[j] = a2;
        assign o3[j] = a3;
    end
endmodule

// File: rtl/sperm_round.sv
module sperm_round #(
    parameter int unsigned ROW_W = sperm_pkg::ROW_W_DEF,
    parameter int unsigned RC_W  = sperm_pkg::RC_W_DEF,
    parameter int unsigned ROT1  = sperm_pkg::ROT1_DEF,
    parameter int unsigned ROT2  = sperm_pkg::ROT2_DEF,
    parameter int unsigned ROT3  = sperm_pkg::ROT3_DEF
) (
    input  logic [sperm_pkg::ROWS*ROW_W-1:0] st_i,
    input  logic [RC_W-1:0]                  rc_i,
    output logic [sperm_pkg::ROWS*ROW_W-1:0] st_o
);
    localparam int unsigned ROWS = sperm_pkg::ROWS;

    logic [ROW_W-1:0] row_in  [ROWS];
    logic [ROW_W-1:0] row_sb  [ROWS];
    logic [ROW_W-1:0] row_out [ROWS];
    logic [ROW_W-1:0] row0_k;

    for (genvar r = 0; r < ROWS; r++) begin : g_unpack
        assign row_in[r] = st_i[r*ROW_W +: ROW_W];
        assign st_o[r*ROW_W +: ROW_W] = row_out[r];
    end

    assign row0_k = row_in[0] ^ {{(ROW_W-RC_W){1'b0}}, rc_i};

    sperm_sbox #(.W(ROW_W)) u_sbox (
        .i0(row0_k),    .i1(row_in[1]), .i2(row_in[2]), .i3(row_in[3]),
        .o0(row_sb[0]), .o1(row_sb[1]), .o2(row_sb[2]), .o3(row_sb[3])
    );

    assign row_out[0] = row_sb[0];
    sperm_rotl #(.W(ROW_W), .K(ROT1)) u_rot1 (.x(row_sb[1]), .y(row_out[1]));
    sperm_rotl #(.W(ROW_W), .K(ROT2)) u_rot2 (.x(row_sb[2]), .y(row_out[2]));
    sperm_rotl #(.W(ROW_W), .K(ROT3)) u_rot3 (.x(row_sb[3]), .y(row_out[3]));
endmodule

// File: rtl/sperm_rcgen.sv
module sperm_rcgen #(
    parameter int unsigned RC_W = sperm_pkg::RC_W_DEF
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            restart,
    input  logic            advance,
    output logic [RC_W-1:0] rc
);
    localparam logic [RC_W-1:0] RC_SEED = RC_W'(1);

    logic [RC_W-1:0] rc_d, rc_q;

    always_comb begin
        rc_d = rc_q;
        if (restart) begin
            rc_d = RC_SEED;
        end else if (advance) begin
            rc_d = {rc_q[RC_W-2:0], rc_q[RC_W-1] ^ rc_q[RC_W-2]};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rc_q <= RC_SEED;
        else        rc_q <= rc_d;
    end

    assign rc = rc_q;

    // R5: a seeded register of this shape never collapses to zero
    always_comb begin
        if (rst_n) assert_rc_nonzero_R5: assert (rc_q != '0);
    end

    // R5: a restart always returns the seed on the next cycle
    assert_rc_seed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (rc_q == RC_SEED));
endmodule

// File: rtl/sperm_core.sv
module sperm_core #(
    parameter int unsigned ROW_W = sperm_pkg::ROW_W_DEF,
    parameter int unsigned RC_W  = sperm_pkg::RC_W_DEF,
    parameter int unsigned CNT_W = sperm_pkg::CNT_W_DEF
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             start,
    input  logic [CNT_W-1:0]                 rounds_in,
    input  logic [sperm_pkg::ROWS*ROW_W-1:0] state_in,
    output logic                             busy,
    output logic                             done,
    output logic [sperm_pkg::ROWS*ROW_W-1:0] state_out
);
    localparam int unsigned ST_W = sperm_pkg::ROWS * ROW_W;

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [CNT_W-1:0] cnt;
        logic [ST_W-1:0]  st;
    } ctl_t;

    ctl_t            r_d, r_q;
    logic [RC_W-1:0] rc;
    logic [ST_W-1:0] rnd_out;
    logic            accept;

    assign accept = start & ~r_q.busy;

    sperm_rcgen #(.RC_W(RC_W)) u_rcgen (
        .clk(clk), .rst_n(rst_n),
        .restart(accept), .advance(r_q.busy), .rc(rc)
    );

    sperm_round #(.ROW_W(ROW_W), .RC_W(RC_W)) u_round (
        .st_i(r_q.st), .rc_i(rc), .st_o(rnd_out)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        if (r_q.busy) begin
            r_d.st  = rnd_out;
            r_d.cnt = r_q.cnt - 1'b1;
            if (r_q.cnt == CNT_W'(1)) begin
                r_d.busy = 1'b0;
                r_d.done = 1'b1;
            end
        end else if (start) begin
            r_d.st  = state_in;
            r_d.cnt = rounds_in;
            if (rounds_in == '0) r_d.done = 1'b1;
            else                 r_d.busy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy      = r_q.busy;
    assign done      = r_q.done;
    assign state_out = r_q.st;

    // R7: completion is a single-cycle pulse
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R6: while busy, rounds remain to be run
    assert_cnt_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (r_q.cnt != '0));

    // R9: a job with rounds left keeps running whatever start does
    assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && r_q.cnt != CNT_W'(1)) |=> busy);

    // R8: idle without a request leaves the result untouched
    assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(state_out));

    // R10: a zero-round request finishes at once and never goes busy
    assert_zero_direct_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && rounds_in == '0) |=> (done && !busy));
endmodule

// File: tb/sperm_core_bench.sv
`timescale 1ns/1ps
module sperm_core_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [7:0]   rounds_in = '0;
    logic [383:0] state_in = '0;
    logic         busy, done;
    logic [383:0] state_out;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    sperm_core u_sperm_core (
        .clk(clk), .rst_n(rst_n), .start(start), .rounds_in(rounds_in),
        .state_in(state_in), .busy(busy), .done(done), .state_out(state_out)
    );

    // ---------------- reference model ----------------
    function automatic logic [6:0] m_lfsr(input logic [6:0] c);
        return {c[5:0], c[6] ^ c[5]};
    endfunction

    function automatic logic [383:0] m_round(input logic [383:0] s, input logic [6:0] c);
        logic [95:0] a0, a1, a2, a3, t;
        a0 = s[95:0] ^ {89'd0, c};
        a1 = s[191:96];
        a2 = s[287:192];
        a3 = s[383:288];
        t  = a1;  a0 = ~a0;  a1 = a1 & a0;  a1 = a1 ^ a2;
        a2 = a2 | t;  a0 = a0 ^ a3;  a2 = a2 ^ a0;  t = t ^ a3;
        a0 = a0 & a1;  a3 = a3 ^ a1;  a0 = a0 ^ t;  t = t & a2;
        a1 = a1 ^ t;
        return {{a3[40:0], a3[95:41]}, {a2[87:0], a2[95:88]},
                {a1[94:0], a1[95]}, a0};
    endfunction

    function automatic logic [383:0] m_perm(input logic [383:0] s, input int n);
        logic [6:0] c = 7'h01;
        for (int i = 0; i < n; i++) begin
            s = m_round(s, c);
            c = m_lfsr(c);
        end
        return s;
    endfunction

    function automatic logic [383:0] rnd_state();
        logic [383:0] v;
        for (int i = 0; i < 12; i++) v[i*32 +: 32] = $urandom;
        return v;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [383:0] act,
                       input logic [383:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive start for one cycle; returns at the negedge after the sampling edge
    task automatic kick(input logic [383:0] s, input logic [7:0] n);
        @(negedge clk);
        start = 1'b1; state_in = s; rounds_in = n;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(inout int lat);
        while (!done && lat < 400) begin
            @(negedge clk);
            lat++;
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(busy == 1'b0, "R12 busy", 384'(busy), 384'(0));
        chk(done == 1'b0, "R12 done", 384'(done), 384'(0));
        chk(state_out == '0, "R12 state_out", state_out, '0);
    endtask

    task automatic t_lfsr_model();
        logic [6:0] exp16 [16] = '{7'h01, 7'h02, 7'h04, 7'h08, 7'h10, 7'h20, 7'h41, 7'h03,
                                   7'h06, 7'h0c, 7'h18, 7'h30, 7'h61, 7'h42, 7'h05, 7'h0a};
        logic [6:0] c = 7'h01;
        int per = 0;
        for (int i = 0; i < 16; i++) begin
            chk(c == exp16[i], "R5 constant sequence", 384'(c), 384'(exp16[i]));
            c = m_lfsr(c);
        end
        c = 7'h01;
        do begin c = m_lfsr(c); per++; end while (c != 7'h01 && per < 200);
        chk(per == 127, "R5 constant period", 384'(per), 384'(127));
    endtask

    // R1 R2 R3 R4 R5 R6 R7 R8: one job, checked for latency, value and hold
    task automatic t_run(input logic [383:0] s, input int n, input string tag);
        int lat = 0;
        logic [383:0] exp = m_perm(s, n);
        kick(s, 8'(n));
        if (n > 0) chk(busy == 1'b1, {"R7 busy during ", tag}, 384'(busy), 384'(1));
        wait_done(lat);
        chk(lat == n, {"R6 latency ", tag}, 384'(lat), 384'(n));
        chk(state_out == exp, {"R3 R4 result ", tag}, state_out, exp);
        chk(busy == 1'b0, {"R7 busy at done ", tag}, 384'(busy), 384'(0));
        @(negedge clk);
        chk(done == 1'b0, {"R7 done pulse ", tag}, 384'(done), 384'(0));
        repeat (3) @(negedge clk);
        chk(state_out == exp, {"R8 result held ", tag}, state_out, exp);
    endtask

    task automatic t_zero();
        logic [383:0] s = rnd_state();
        kick(s, 8'd0);
        chk(done == 1'b1, "R10 immediate done", 384'(done), 384'(1));
        chk(busy == 1'b0, "R10 no busy", 384'(busy), 384'(0));
        chk(state_out == s, "R10 passthrough", state_out, s);
        @(negedge clk);
        chk(done == 1'b0, "R10 done pulse", 384'(done), 384'(0));
    endtask

    // R9: start mid-run and in the final-round cycle are both dropped
    task automatic t_busy_start();
        logic [383:0] a = rnd_state();
        logic [383:0] b = rnd_state();
        logic [383:0] ea = m_perm(a, 5);
        int lat = 0;
        kick(a, 8'd5);
        @(negedge clk); lat++;
        start = 1'b1; state_in = b; rounds_in = 8'd2;
        @(negedge clk); lat++;
        start = 1'b0;
        wait_done(lat);
        chk(lat == 5, "R9 latency unchanged", 384'(lat), 384'(5));
        chk(state_out == ea, "R9 mid-run start ignored", state_out, ea);
        ea = m_perm(a, 4);
        lat = 0;
        kick(a, 8'd4);
        while (lat < 3) begin @(negedge clk); lat++; end
        start = 1'b1; state_in = b; rounds_in = 8'd0;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b1, "R9 final-round done", 384'(done), 384'(1));
        chk(state_out == ea, "R9 final-round start ignored", state_out, ea);
        @(negedge clk);
        chk(busy == 1'b0 && state_out == ea, "R9 no second job", state_out, ea);
    endtask

    // R11: start while done is high launches the next job
    task automatic t_chain();
        logic [383:0] a = rnd_state();
        logic [383:0] b = rnd_state();
        logic [383:0] eb = m_perm(b, 3);
        int lat = 0;
        kick(a, 8'd2);
        wait_done(lat);
        chk(state_out == m_perm(a, 2), "R11 first result", state_out, m_perm(a, 2));
        start = 1'b1; state_in = b; rounds_in = 8'd3;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R11 second job accepted", 384'(busy), 384'(1));
        lat = 0;
        wait_done(lat);
        chk(lat == 3, "R11 second latency", 384'(lat), 384'(3));
        chk(state_out == eb, "R11 second result", state_out, eb);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_lfsr_model();
        t_run('0, 1, "zero state 1 round");
        t_run({4{96'h1}}, 2, "R1 column 0 pattern");
        t_run(rnd_state(), 1, "random 1");
        t_run(rnd_state(), 12, "random 12");
        t_run(rnd_state(), 31, "random 31");
        t_run(rnd_state(), 130, "R5 past period");
        t_zero();
        t_busy_start();
        t_chain();
        t_run(rnd_state(), 255, "max count");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule